// File: doc/BRIEF.md
# Configurable pixel format unpacker

This block takes a stream of 32-bit words that hold packed pixels and turns it into a stream of 32-bit pixels with 8 bits each for alpha, red, green and blue (alpha in the top byte, blue in the bottom byte). Pixels are 1 to 4 bytes long. They are packed back to back in little-endian byte order and may cross word boundaries. A 3-bit selector picks one of six built-in layouts or a run-time layout. In the run-time layout, two configuration inputs give the pixel size and, for each channel, a field position and a field length. This covers any RGB arrangement, including single-byte luminance or index data, which is copied to all three colour channels.

Both sides use valid/ready handshakes. A byte residue buffer holds leftover bytes between words. A synchronous start-of-frame pulse empties this buffer and loads a new configuration. A configuration can also be loaded while the stream is idle. An unusable configuration produces no pixels and sets a sticky error flag.

Top module: `pix_unpack`

## Requirements
- R1: Selector codes 0 to 6 use fixed layouts. Field notation is position/length in the little-endian pixel value. Code 0 is 4 bytes with a 24/8, r 16/8, g 8/8, b 0/8. Code 1 is 4 bytes with a 24/8, b 16/8, g 8/8, r 0/8. Code 2 is 4 bytes with r 24/8, g 16/8, b 8/8, a 0/8. Code 4 is 2 bytes with r 11/5, g 5/6, b 0/5 and no alpha. Code 5 is 2 bytes with b 11/5, g 5/6, r 0/5 and no alpha. Code 6 is 3 bytes with r 16/8, g 8/8, b 0/8 and no alpha. Code 3 is reserved.
- R2: Selector code 7 takes the layout from the configuration inputs. `fmt_cfg0` holds alpha position [4:0], alpha length [8:5], red position [13:9] and red length [17:14]. `fmt_cfg1` holds green position [4:0], green length [8:5], blue position [13:9], blue length [17:14] and pixel size in bytes [20:18]. Fields may overlap, so one field can feed red, green and blue.
- R3: A field of length L from 1 to 7 is widened to 8 bits. Its bits go to the top of the output, and the field is repeated downward to fill the rest. A length-1 field therefore becomes 0x00 or 0xFF. Lengths above 8 are treated as 8. A colour field of length 0 gives 0x00.
- R4: An alpha length of 0 gives output alpha 0xFF.
- R5: Pixel bytes are taken in stream order: byte 0 of each word first, with no padding between pixels or words. Pixel byte k is bits [8k+7:8k] of the pixel value.
- R6: `in_ready` is high while a full word fits in the residue buffer (8 bytes by default) and `sof` is low. With the output stalled and a 4-byte layout, exactly three words are accepted before `in_ready` falls.
- R7: A pixel whose last byte arrives with a word accepted at clock edge e is presented on `out_valid`/`out_argb` after edge e+1, if the output slot is free. While `out_valid` is high and `out_ready` is low, the output holds steady.
- R8: A `sof` pulse discards all buffered bytes and any pending output pixel. It also loads the layout from the selector and configuration inputs.
- R9: Without `sof`, a new layout is loaded only when the buffer is empty, no pixel is pending and `in_valid` is low. Changes made while words are streaming have no effect on the pixels.
- R10: Selector 3, or selector 7 with a pixel size of 0 or more than 4, produces no pixels. Words are still accepted and thrown away. `fmt_err` goes high and stays high until reset, even after a valid layout is loaded.
- R11: After reset, `out_valid` is low, `fmt_err` is low, `in_ready` is high, and the layout is selector code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse: clear buffer and load layout |
| fmt_sel | input | 3 | Layout selector (0-6 fixed, 7 run-time) |
| fmt_cfg0 | input | 18 | Alpha and red field position/length |
| fmt_cfg1 | input | 21 | Green and blue field position/length, pixel size |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Packed pixel word, byte 0 first in stream |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_argb | output | 32 | Pixel as {A,R,G,B}, 8 bits each |
| fmt_err | output | 1 | Sticky unusable-layout flag |

## Verification
Each word handshake takes effect at one clock edge. A pixel completed by that word appears one edge later, so the bench samples both sides at the falling edge and counts edges from the accepted word. A directed case checks `out_valid` is low one falling edge after acceptance and high with the right value one edge later. The stall case counts accepted words against the three-word limit and checks the held value over several cycles. The error flag is read several cycles after the bad layout is loaded, because it passes through the layout register first.

// File: rtl/pu_pkg.sv
// Shared types and fixed layout table for the pixel unpacker.
// Assumes positions fit 5 bits, lengths 4 bits and pixel size 3 bits.
package pu_pkg;
    localparam int POS_W  = 5;
    localparam int LEN_W  = 4;
    localparam int SIZE_W = 3;
    localparam int CFG0_W = 18;
    localparam int CFG1_W = 21;

    localparam logic [2:0] SEL_ARGB   = 3'd0;
    localparam logic [2:0] SEL_ABGR   = 3'd1;
    localparam logic [2:0] SEL_RGBA   = 3'd2;
    localparam logic [2:0] SEL_RSVD   = 3'd3;
    localparam logic [2:0] SEL_RGB565 = 3'd4;
    localparam logic [2:0] SEL_BGR565 = 3'd5;
    localparam logic [2:0] SEL_RGB888 = 3'd6;
    localparam logic [2:0] SEL_FLEX   = 3'd7;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [POS_W-1:0]  a_pos;
        logic [LEN_W-1:0]  a_len;
        logic [POS_W-1:0]  r_pos;
        logic [LEN_W-1:0]  r_len;
        logic [POS_W-1:0]  g_pos;
        logic [LEN_W-1:0]  g_len;
        logic [POS_W-1:0]  b_pos;
        logic [LEN_W-1:0]  b_len;
    } pu_layout_t;

    // Build a layout record from plain integers.
    function automatic pu_layout_t pu_mk(input int s, input int ap, input int al,
                                         input int rp, input int rl, input int gp,
                                         input int gl, input int bp, input int bl);
        pu_layout_t l;
        l.size  = SIZE_W'(s);
        l.a_pos = POS_W'(ap);
        l.a_len = LEN_W'(al);
        l.r_pos = POS_W'(rp);
        l.r_len = LEN_W'(rl);
        l.g_pos = POS_W'(gp);
        l.g_len = LEN_W'(gl);
        l.b_pos = POS_W'(bp);
        l.b_len = LEN_W'(bl);
        return l;
    endfunction

    // Built-in layouts; reserved and run-time codes fall back to code 0.
    function automatic pu_layout_t pu_fixed(input logic [2:0] sel);
        case (sel)
            SEL_ABGR:   return pu_mk(4, 24, 8,  0, 8,  8, 8, 16, 8);
            SEL_RGBA:   return pu_mk(4,  0, 8, 24, 8, 16, 8,  8, 8);
            SEL_RGB565: return pu_mk(2,  0, 0, 11, 5,  5, 6,  0, 5);
            SEL_BGR565: return pu_mk(2,  0, 0,  0, 5,  5, 6, 11, 5);
            SEL_RGB888: return pu_mk(3,  0, 0, 16, 8,  8, 8,  0, 8);
            default:    return pu_mk(4, 24, 8, 16, 8,  8, 8,  0, 8);
        endcase
    endfunction
endpackage

// File: rtl/pu_fmt_decode.sv
// Turns the selector and configuration inputs into a layout record.
// Purely combinational; flags codes that cannot produce pixels.
module pu_fmt_decode
    import pu_pkg::*;
(
    input  logic [2:0]        sel,
    input  logic [CFG0_W-1:0] cfg0,
    input  logic [CFG1_W-1:0] cfg1,
    output pu_layout_t        lay,
    output logic              bad
);
    // Pick fixed table entry or unpack the run-time fields.
    always_comb begin
        if (sel == SEL_FLEX) begin
            lay.a_pos = cfg0[4:0];
            lay.a_len = cfg0[8:5];
            lay.r_pos = cfg0[13:9];
            lay.r_len = cfg0[17:14];
            lay.g_pos = cfg1[4:0];
            lay.g_len = cfg1[8:5];
            lay.b_pos = cfg1[13:9];
            lay.b_len = cfg1[17:14];
            lay.size  = cfg1[20:18];
            bad = (cfg1[20:18] == 3'd0) || (cfg1[20:18] > 3'd4);
        end else begin
            lay = pu_fixed(sel);
            bad = (sel == SEL_RSVD);
        end
    end
endmodule

// File: rtl/pu_byte_fifo.sv
// Byte residue buffer: accepts a whole 32-bit word, releases 1..4 bytes
// from its head. The head is always at index 0 (shift-down storage).
// Assumes BUF_BYTES >= 8 so a word fits whenever 4 or fewer bytes remain.
module pu_byte_fifo #(
    parameter int BUF_BYTES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [31:0]                    wdata,
    input  logic                           pop,
    input  logic [2:0]                     pop_n,
    output logic [$clog2(BUF_BYTES+1)-1:0] cnt,
    output logic [31:0]                    head,
    output logic                           room
);
    localparam int CW = $clog2(BUF_BYTES+1);

    logic [7:0]    mem     [BUF_BYTES];
    logic [7:0]    mem_nxt [BUF_BYTES];
    logic [CW-1:0] cnt_nxt;
    int            pn;
    int            base;

    // Shift out popped bytes and append the pushed word behind the rest.
    always_comb begin
        pn   = pop ? int'(pop_n) : 0;
        base = int'(cnt) - pn;
        for (int i = 0; i < BUF_BYTES; i++) begin
            if (i + pn < BUF_BYTES) mem_nxt[i] = mem[i + pn];
            else                    mem_nxt[i] = 8'h00;
            if (push && i >= base && i < base + 4)
                mem_nxt[i] = wdata[8*(i-base) +: 8];
        end
        cnt_nxt = CW'(base + (push ? 4 : 0));
    end

    // Storage and fill level update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            for (int i = 0; i < BUF_BYTES; i++) mem[i] <= 8'h00;
        end else begin
            cnt <= cnt_nxt;
            for (int i = 0; i < BUF_BYTES; i++) mem[i] <= mem_nxt[i];
        end
    end

    assign head = {mem[3], mem[2], mem[1], mem[0]};
    assign room = (int'(cnt) <= BUF_BYTES - 4);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (int'(cnt) <= BUF_BYTES - 4)); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (int'(cnt) >= int'(pop_n))); // R5
endmodule

// File: rtl/pu_chan_expand.sv
// Extracts one channel field from a pixel value and widens it to 8 bits
// by bit repetition. Lengths above 8 are clamped to 8.
module pu_chan_expand
    import pu_pkg::*;
#(
    parameter bit IS_ALPHA = 1'b0
) (
    input  logic [31:0]      pix,
    input  logic [POS_W-1:0] pos,
    input  logic [LEN_W-1:0] len,
    output logic [7:0]       val
);
    logic [31:0] shifted;
    logic [7:0]  fld;
    int          eff;

    // Isolate the field bits at the bottom of the byte.
    always_comb begin
        shifted = pix >> pos;
        eff     = (len > LEN_W'(8)) ? 8 : int'(len);
        for (int b = 0; b < 8; b++) fld[b] = (b < eff) ? shifted[b] : 1'b0;
    end

    // Widen by repeating the field from the MSB downwards.
    always_comb begin
        if (eff == 0) begin
            val = IS_ALPHA ? 8'hFF : 8'h00;
        end else begin
            for (int i = 0; i < 8; i++)
                val[i] = fld[eff - 1 - ((7 - i) % eff)];
        end
    end
endmodule

// File: rtl/pix_unpack.sv
// Top of the pixel unpacker. Holds the active layout register, the byte
// residue buffer, four channel expanders and a one-deep output register.
// Assumes sof is a single-cycle pulse; layout loads on sof or when idle.
module pix_unpack
    import pu_pkg::*;
#(
    parameter int BUF_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic [2:0]        fmt_sel,
    input  logic [CFG0_W-1:0] fmt_cfg0,
    input  logic [CFG1_W-1:0] fmt_cfg1,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_argb,
    output logic              fmt_err
);
    localparam int CW = $clog2(BUF_BYTES+1);
    localparam int NCH = 4;

    pu_layout_t    dec_lay;
    logic          dec_bad;
    pu_layout_t    act_lay;
    logic          act_bad;
    logic          cfg_load;
    logic [CW-1:0] cnt;
    logic [31:0]   head;
    logic          room;
    logic          push;
    logic          pop;
    logic [31:0]   pix_m;
    logic [POS_W-1:0] ch_pos [NCH];
    logic [LEN_W-1:0] ch_len [NCH];
    logic [7:0]       ch_val [NCH];

    pu_fmt_decode u_dec (
        .sel  (fmt_sel),
        .cfg0 (fmt_cfg0),
        .cfg1 (fmt_cfg1),
        .lay  (dec_lay),
        .bad  (dec_bad)
    );

    assign cfg_load = sof || (cnt == '0 && !out_valid && !in_valid);

    // Active layout register, reloaded on sof or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_lay <= pu_fixed(SEL_ARGB);
            act_bad <= 1'b0;
        end else if (cfg_load) begin
            act_lay <= dec_lay;
            act_bad <= dec_bad;
        end
    end

    assign in_ready = !sof && (act_bad || room);
    assign push     = in_valid && in_ready && !act_bad;
    assign pop      = !sof && !act_bad && (cnt >= CW'(act_lay.size))
                      && (!out_valid || out_ready);

    pu_byte_fifo #(.BUF_BYTES(BUF_BYTES)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sof),
        .push  (push),
        .wdata (in_data),
        .pop   (pop),
        .pop_n (act_lay.size),
        .cnt   (cnt),
        .head  (head),
        .room  (room)
    );

    // Keep only the bytes that belong to the current pixel.
    always_comb begin
        for (int b = 0; b < 4; b++)
            pix_m[8*b +: 8] = (b < int'(act_lay.size)) ? head[8*b +: 8] : 8'h00;
    end

    // Channel order: 3 alpha, 2 red, 1 green, 0 blue.
    always_comb begin
        ch_pos[3] = act_lay.a_pos;  ch_len[3] = act_lay.a_len;
        ch_pos[2] = act_lay.r_pos;  ch_len[2] = act_lay.r_len;
        ch_pos[1] = act_lay.g_pos;  ch_len[1] = act_lay.g_len;
        ch_pos[0] = act_lay.b_pos;  ch_len[0] = act_lay.b_len;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pu_chan_expand #(.IS_ALPHA(c == 3)) u_exp (
            .pix (pix_m),
            .pos (ch_pos[c]),
            .len (ch_len[c]),
            .val (ch_val[c])
        );
    end

    // One-deep output register with valid/ready hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_argb  <= '0;
        end else if (sof) begin
            out_valid <= 1'b0;
        end else if (pop) begin
            out_valid <= 1'b1;
            out_argb  <= {ch_val[3], ch_val[2], ch_val[1], ch_val[0]};
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Sticky flag for a layout that cannot produce pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) fmt_err <= 1'b0;
        else        fmt_err <= fmt_err | act_bad;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !sof |=> out_valid && $stable(out_argb)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err); // R10
    AST_NO_PIX_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        act_bad && !out_valid |=> !out_valid); // R10
    AST_SOF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (cnt == '0) && !out_valid); // R8
endmodule

// File: tb/tb_pix_unpack.sv
module tb_pix_unpack;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic [17:0] fmt_cfg0 = '0;
    logic [20:0] fmt_cfg1 = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_argb;
    logic        fmt_err;

    pix_unpack #(.BUF_BYTES(8)) dut (
        .clk(clk), .rst_n(rst_n), .sof(sof), .fmt_sel(fmt_sel),
        .fmt_cfg0(fmt_cfg0), .fmt_cfg1(fmt_cfg1), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_argb(out_argb), .fmt_err(fmt_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    int e_size, e_apos, e_alen, e_rpos, e_rlen, e_gpos, e_glen, e_bpos, e_blen;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_lay(input int s, input int ap, input int al, input int rp,
                           input int rl, input int gp, input int gl, input int bp,
                           input int bl);
        e_size = s; e_apos = ap; e_alen = al; e_rpos = rp; e_rlen = rl;
        e_gpos = gp; e_glen = gl; e_bpos = bp; e_blen = bl;
    endtask

    function automatic logic [17:0] mk0(input int ap, input int al, input int rp, input int rl);
        return 18'((rl << 14) | (rp << 9) | (al << 5) | ap);
    endfunction

    function automatic logic [20:0] mk1(input int gp, input int gl, input int bp, input int bl,
                                        input int s);
        return 21'((s << 18) | (bl << 14) | (bp << 9) | (gl << 5) | gp);
    endfunction

    // Widen by concatenating copies of the field until 8 bits are covered.
    function automatic int widen(input logic [31:0] p, input int pos, input int len,
                                 input bit alpha);
        int l = (len > 8) ? 8 : len;
        int v, r, bits;
        if (l == 0) return alpha ? 255 : 0;
        v = int'((p >> pos) & ((32'd1 << l) - 32'd1));
        r = 0; bits = 0;
        while (bits < 8) begin
            r = (r << l) | v;
            bits += l;
        end
        return (r >> (bits - 8)) & 255;
    endfunction

    function automatic logic [31:0] raw_pix(input int i);
        logic [31:0] h = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A1234 ^ (32'(i) << 13);
        if (e_size < 4) h = h & ((32'd1 << (8 * e_size)) - 32'd1);
        return h;
    endfunction

    function automatic logic [31:0] exp_pix(input logic [31:0] p);
        return {8'(widen(p, e_apos, e_alen, 1'b1)), 8'(widen(p, e_rpos, e_rlen, 1'b0)),
                8'(widen(p, e_gpos, e_glen, 1'b0)), 8'(widen(p, e_bpos, e_blen, 1'b0))};
    endfunction

    function automatic logic [7:0] sbyte(input int j);
        return 8'(raw_pix(j / e_size) >> (8 * (j % e_size)));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; sof = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic apply_cfg(input logic [2:0] s, input logic [17:0] c0,
                             input logic [20:0] c1, input bit with_sof);
        @(negedge clk);
        fmt_sel = s; fmt_cfg0 = c0; fmt_cfg1 = c1; sof = with_sof;
        @(negedge clk);
        sof = 1'b0;
        @(negedge clk);
    endtask

    task automatic producer(input int nwords, input int gap, input int chg_at);
        bit rdy;
        for (int w = 0; w < nwords; w++) begin
            if (gap > 0 && (w % gap) == gap - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            if (w == chg_at) begin
                fmt_sel = 3'd0; fmt_cfg0 = 18'h3FFFF; fmt_cfg1 = 21'h1FFFFF;
            end
            in_valid = 1'b1;
            in_data = {sbyte(4*w+3), sbyte(4*w+2), sbyte(4*w+1), sbyte(4*w)};
            forever begin
                rdy = in_ready;
                @(posedge clk);
                if (rdy) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic consumer(input int npix, input int rmode, input string req);
        int got = 0;
        int cyc = 0;
        logic [31:0] e;
        while (got < npix) begin
            @(negedge clk);
            out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
            cyc++;
            if (out_valid && out_ready) begin
                e = exp_pix(raw_pix(got));
                check(out_argb == e, req, out_argb, e);
                got++;
            end
        end
    endtask

    task automatic run(input logic [2:0] s, input logic [17:0] c0, input logic [20:0] c1,
                       input int npix, input int rmode, input int gap, input bit with_sof,
                       input int chg_at, input string req);
        apply_cfg(s, c0, c1, with_sof);
        fork
            producer((npix * e_size + 3) / 4, gap, chg_at);
            consumer(npix, rmode, req);
        join
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog actual=%0d cycles expected<%0d", MAX_CYC, MAX_CYC);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held;
        int acc;
        bit rdy;
        do_reset();
        // R11 reset state
        check(out_valid == 1'b0, "R11", 32'(out_valid), 32'd0);
        check(fmt_err == 1'b0, "R11", 32'(fmt_err), 32'd0);
        check(in_ready == 1'b1, "R11", 32'(in_ready), 32'd1);

        // R1 fixed layouts, with stream and output backpressure patterns
        set_lay(4, 24, 8, 16, 8, 8, 8, 0, 8);  run(3'd0, '0, '0, 40, 0, 0, 1, -1, "R1");
        set_lay(4, 24, 8, 0, 8, 8, 8, 16, 8);  run(3'd1, '0, '0, 40, 1, 3, 1, -1, "R1");
        set_lay(4, 0, 8, 24, 8, 16, 8, 8, 8);  run(3'd2, '0, '0, 40, 1, 0, 1, -1, "R1");
        set_lay(2, 0, 0, 11, 5, 5, 6, 0, 5);   run(3'd4, '0, '0, 40, 0, 4, 1, -1, "R1_R3");
        set_lay(2, 0, 0, 0, 5, 5, 6, 11, 5);   run(3'd5, '0, '0, 40, 1, 2, 1, -1, "R1_R3");
        set_lay(3, 0, 0, 16, 8, 8, 8, 0, 8);   run(3'd6, '0, '0, 40, 1, 3, 1, -1, "R1_R5");

        // R2 run-time layouts; R4 alpha absent; R3 widening and clamp
        set_lay(3, 0, 0, 0, 8, 8, 8, 16, 8);
        run(3'd7, mk0(0, 0, 0, 8), mk1(8, 8, 16, 8, 3), 40, 1, 0, 1, -1, "R2_R4");
        set_lay(2, 15, 1, 10, 5, 5, 5, 0, 5);
        run(3'd7, mk0(15, 1, 10, 5), mk1(5, 5, 0, 5, 2), 40, 0, 3, 1, -1, "R2_R3");
        set_lay(2, 12, 4, 8, 4, 4, 4, 0, 4);
        run(3'd7, mk0(12, 4, 8, 4), mk1(4, 4, 0, 4, 2), 40, 1, 0, 1, -1, "R2_R3");
        set_lay(1, 0, 0, 0, 8, 0, 8, 0, 8);
        run(3'd7, mk0(0, 0, 0, 8), mk1(0, 8, 0, 8, 1), 40, 1, 2, 1, -1, "R2_R4_R5");
        set_lay(1, 4, 4, 0, 4, 0, 4, 0, 4);
        run(3'd7, mk0(4, 4, 0, 4), mk1(0, 4, 0, 4, 1), 40, 0, 0, 1, -1, "R2_R3");
        set_lay(2, 8, 8, 0, 8, 0, 8, 0, 8);
        run(3'd7, mk0(8, 8, 0, 8), mk1(0, 8, 0, 8, 2), 40, 1, 0, 1, -1, "R2");
        set_lay(4, 29, 3, 20, 7, 11, 2, 0, 12);
        run(3'd7, mk0(29, 3, 20, 7), mk1(11, 2, 0, 12, 4), 40, 1, 3, 1, -1, "R3_clamp");

        // R7 latency: word at edge e, pixel visible after edge e+1
        set_lay(4, 24, 8, 16, 8, 8, 8, 0, 8);
        apply_cfg(3'd0, '0, '0, 1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; in_data = raw_pix(0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R7_early", 32'(out_valid), 32'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R7_due", 32'(out_valid), 32'd1);
        check(out_argb == exp_pix(raw_pix(0)), "R7_value", out_argb, exp_pix(raw_pix(0)));
        @(negedge clk);
        check(out_valid == 1'b0, "R7_taken", 32'(out_valid), 32'd0);
        out_ready = 1'b0;

        // R6 stall: three 4-byte words fit with output blocked
        apply_cfg(3'd0, '0, '0, 1);
        acc = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = raw_pix(acc);
            rdy = in_ready;
            @(posedge clk);
            if (rdy) acc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(acc == 3, "R6_count", 32'(acc), 32'd3);
        check(in_ready == 1'b0, "R6_ready", 32'(in_ready), 32'd0);
        held = out_argb;
        repeat (3) @(negedge clk);
        check(out_valid && out_argb == held, "R7_hold", out_argb, held);
        consumer(3, 0, "R6_drain");
        @(negedge clk);
        out_ready = 1'b0;

        // R8: residue byte left behind, then sof must discard it
        set_lay(3, 0, 0, 16, 8, 8, 8, 0, 8);
        run(3'd6, '0, '0, 1, 0, 0, 1, -1, "R8_pre");
        set_lay(4, 24, 8, 16, 8, 8, 8, 0, 8);
        run(3'd0, '0, '0, 12, 0, 0, 1, -1, "R8");

        // R9: change mid-stream ignored, then loaded while idle
        set_lay(3, 0, 0, 16, 8, 8, 8, 0, 8);
        run(3'd6, '0, '0, 8, 0, 0, 1, 2, "R9_busy");
        set_lay(2, 0, 0, 11, 5, 5, 6, 0, 5);
        run(3'd4, '0, '0, 10, 0, 0, 0, -1, "R9_idle");

        // R10: reserved code, sticky flag, words accepted and dropped
        apply_cfg(3'd3, '0, '0, 1);
        acc = 0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 32'hDEAD0000 + 32'(c);
            if (in_ready) acc++;
            check(out_valid == 1'b0, "R10_nopix", 32'(out_valid), 32'd0);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(acc == 3, "R10_accept", 32'(acc), 32'd3);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10_nopix", 32'(out_valid), 32'd0);
        check(fmt_err == 1'b1, "R10_flag", 32'(fmt_err), 32'd1);
        set_lay(4, 24, 8, 16, 8, 8, 8, 0, 8);
        run(3'd0, '0, '0, 4, 0, 0, 1, -1, "R10_recover");
        check(fmt_err == 1'b1, "R10_sticky", 32'(fmt_err), 32'd1);
        do_reset();
        check(fmt_err == 1'b0, "R10_clear", 32'(fmt_err), 32'd0);
        apply_cfg(3'd7, mk0(0, 0, 0, 8), mk1(0, 8, 0, 8, 0), 1);
        repeat (3) @(negedge clk);
        check(fmt_err == 1'b1, "R10_size0", 32'(fmt_err), 32'd1);
        do_reset();
        apply_cfg(3'd7, mk0(0, 0, 0, 8), mk1(0, 8, 0, 8, 5), 1);
        repeat (3) @(negedge clk);
        check(fmt_err == 1'b1, "R10_size5", 32'(fmt_err), 32'd1);
        check(out_valid == 1'b0, "R10_nopix", 32'(out_valid), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule